// File: doc/BRIEF.md
# Keyed Windowed Watchdog

The block is a watchdog timer driven through a two-register byte bus. A control register holds a 3-bit period select and a window-mode bit. While the period select is nonzero, a prescaled counter runs toward a terminal count. Software keeps the system alive by writing two key bytes, 0x55 then 0xAA, to a service register. The pair need not arrive on consecutive writes. If the period elapses first, or if a wrong byte or an out-of-order key reaches the service register, the block pulses a reset request for one clock.

In window mode, servicing is accepted only in the last quarter of the period. Any service write before that point counts as a fault. The bus carries single register writes with no back-pressure: every write is taken in the cycle it is presented. Read data is combinational on the address.

Top module: `wdt_keyed_watchdog`

## Requirements
- R1: With period select 0 (control bits [2:0] = 000) the watchdog is off. Service writes of any value raise no reset request, and no timeout occurs.
- R2: Reads at address 1 (service) always return 0x00. Reads at address 0 (control) return the period select in bits [2:0] and the window bit in bit 3, with the other bits zero.
- R3: While enabled, a service write of any byte other than 0x55 or 0xAA raises the reset request on the following cycle.
- R4: A 0x55 service write followed later by a 0xAA service write restarts the timeout. Idle cycles and control writes that keep the period select are allowed between the two.
- R5: Repeated 0x55 writes are legal, and the sequence stays armed for the next 0xAA.
- R6: A 0xAA service write with no armed 0x55 raises the reset request on the following cycle.
- R7: With period select n (1 to 7), the reset request rises PRE_DIV * 2^(BASE_LOG2 + 2(n-1)) clock cycles after the last restart when no service occurs.
- R8: With window mode (control bit 3) set, a service write while the count is below terminal minus terminal/4 raises a reset request. Key writes at or above that point are accepted.
- R9: A control write that changes the period select restarts the count and disarms the sequence. A control write that keeps it restarts nothing.
- R10: The reset request is a one-cycle pulse. With the counter and sequence state cleared, the next timeout comes a full period later.
- R11: After reset, the reset request is low and the control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 1 | 0 = control register, 1 = service register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume one register access per cycle, held steady across a clock edge and sampled at that edge. They also assume a rate-select field that is never changed in the same cycle as a service write, because the two addresses are exclusive. The bench drives every write at the falling edge and releases the strobe at the next falling edge, so each write spans exactly one rising edge. Period-sensitive tests place writes at computed distances from the enabling write, on both sides of the window opening and of the terminal count. This keeps the timeout and a service completion from meeting in the same cycle except where that is the point of the test.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int          RATE_W   = 3;
  localparam logic [7:0]  KEY_ARM  = 8'h55;
  localparam logic [7:0]  KEY_FIRE = 8'hAA;
  localparam logic        ADDR_CTL = 1'b0;
  localparam logic        ADDR_SVC = 1'b1;
  localparam int          WIN_BIT  = 3;

  // log2 of the terminal count for a nonzero period select
  function automatic int rate_shift(input logic [RATE_W-1:0] rate, input int base);
    if (rate == '0) return base;
    return base + 2 * (int'(rate) - 1);
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (clear || !run)    pre_q <= '0;
    else if (pre_q == LAST)    pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_period_counter.sv
module wdt_period_counter
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              tick,
  input  logic              restart,
  output logic              expire,
  output logic              win_open,
  output logic              cnt_zero
);
  localparam int CW = BASE_LOG2 + 2 * ((1 << RATE_W) - 2) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;
  logic [CW-1:0] last;
  logic [CW-1:0] open_pt;

  always_comb begin
    term    = {{(CW-1){1'b0}}, 1'b1} << rate_shift(rate, BASE_LOG2);
    last    = term - 1'b1;
    open_pt = term - (term >> 2);
  end

  assign expire   = tick && (cnt_q == last);
  assign win_open = (cnt_q >= open_pt);
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_key_checker.sv
module wdt_key_checker
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enabled,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  input  logic       win_mode,
  input  logic       win_open,
  input  logic       clear,
  output logic       svc_ok,
  output logic       svc_bad,
  output logic       armed
);
  logic is_arm, is_fire, too_early, active;

  always_comb begin
    active    = enabled && svc_wr;
    is_arm    = (svc_data == KEY_ARM);
    is_fire   = (svc_data == KEY_FIRE);
    too_early = win_mode && !win_open;
    svc_bad   = active && (too_early || !(is_arm || (is_fire && armed)));
    svc_ok    = active && !svc_bad && is_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          armed <= 1'b0;
    else if (clear || svc_ok)            armed <= 1'b0;
    else if (active && !svc_bad && is_arm) armed <= 1'b1;
  end
endmodule

// File: rtl/wdt_keyed_watchdog.sv
module wdt_keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int PRE_DIV   = 16,
  parameter int BASE_LOG2 = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst_req
);
  logic [RATE_W-1:0] rate_q;
  logic              win_q;
  logic              enabled, wr_ctl, wr_svc, rate_change;
  logic              tick, expire, win_open, cnt_zero;
  logic              svc_ok, svc_bad, armed;
  logic              fault, restart;

  assign enabled     = (rate_q != '0);
  assign wr_ctl      = bus_we && (bus_addr == ADDR_CTL);
  assign wr_svc      = bus_we && (bus_addr == ADDR_SVC);
  assign rate_change = wr_ctl && (bus_wdata[RATE_W-1:0] != rate_q);
  // a completed key pair on the expiring tick still counts as in time
  assign fault       = svc_bad || (expire && !svc_ok);
  assign restart     = fault || svc_ok || rate_change || !enabled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      win_q  <= 1'b0;
    end else if (wr_ctl) begin
      rate_q <= bus_wdata[RATE_W-1:0];
      win_q  <= bus_wdata[WIN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_rst_req <= 1'b0;
    else        wdt_rst_req <= fault;
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_CTL) begin
      bus_rdata[RATE_W-1:0] = rate_q;
      bus_rdata[WIN_BIT]    = win_q;
    end
  end

  wdt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(enabled), .clear(restart), .tick(tick)
  );

  wdt_period_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rate(rate_q), .tick(tick), .restart(restart),
    .expire(expire), .win_open(win_open), .cnt_zero(cnt_zero)
  );

  wdt_key_checker u_key (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .svc_wr(wr_svc),
    .svc_data(bus_wdata), .win_mode(win_q), .win_open(win_open),
    .clear(fault || rate_change || !enabled),
    .svc_ok(svc_ok), .svc_bad(svc_bad), .armed(armed)
  );
endmodule

// File: rtl/wdt_keyed_watchdog_chk.sv
module wdt_keyed_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       wdt_rst_req,
  input logic [2:0] rate_q,
  input logic       win_q,
  input logic       win_open,
  input logic       armed,
  input logic       cnt_zero
);
  logic svc_en;
  assign svc_en = bus_we && bus_addr && (rate_q != 3'd0);

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 3'd0) |=> !wdt_rst_req);

  assert_svc_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr |-> (bus_rdata == 8'h00));

  assert_bad_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_en && bus_wdata != 8'h55 && bus_wdata != 8'hAA) |=> wdt_rst_req);

  assert_unarmed_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_en && bus_wdata == 8'hAA && !armed) |=> wdt_rst_req);

  assert_early_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_en && win_q && !win_open) |=> wdt_rst_req);

  assert_pulse_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> (cnt_zero && !armed));
endmodule

bind wdt_keyed_watchdog wdt_keyed_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req),
  .rate_q(rate_q), .win_q(win_q), .win_open(win_open), .armed(armed),
  .cnt_zero(cnt_zero)
);

// File: tb/wdt_keyed_watchdog_test.sv
module wdt_keyed_watchdog_test;
  localparam int PRE_DIV   = 2;
  localparam int BASE_LOG2 = 3;
  localparam int P1 = PRE_DIV * (1 << BASE_LOG2);        // rate 1: 16 cycles
  localparam int P2 = PRE_DIV * (1 << (BASE_LOG2 + 2)); // rate 2: 64 cycles
  localparam int OPEN1 = P1 - P1 / 4;                    // 12: last closed edge

  // {addr, data, expected reset request}
  localparam int NV = 13;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 8'h07, 1'b0},  // enable, long period
    {1'b1, 8'h55, 1'b0},  // R5
    {1'b1, 8'h55, 1'b0},  // R5
    {1'b1, 8'hAA, 1'b0},  // R4
    {1'b1, 8'hAA, 1'b1},  // R6 not armed
    {1'b1, 8'h55, 1'b0},
    {1'b1, 8'h13, 1'b1},  // R3
    {1'b1, 8'h55, 1'b0},
    {1'b0, 8'h07, 1'b0},  // R9 same rate keeps armed
    {1'b1, 8'hAA, 1'b0},  // R4 completes
    {1'b0, 8'h00, 1'b0},  // disable
    {1'b1, 8'h13, 1'b0},  // R1
    {1'b1, 8'hAA, 1'b0}   // R1
  };

  logic clk = 0, rst_n = 0, bus_we = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic wdt_rst_req;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdt_keyed_watchdog #(.PRE_DIV(PRE_DIV), .BASE_LOG2(BASE_LOG2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles from the last write edge to the first reset request
  task automatic wait_pulse(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit && k < 0; i++) begin
      @(negedge clk);
      if (wdt_rst_req) k = i;
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      1, 2:     return "R5";
      3, 9:     return "R4";
      4:        return "R6";
      6:        return "R3";
      8:        return "R9";
      11, 12:   return "R1";
      default:  return "R4 setup";
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    int k;
    idle(2);
    rst_n = 1;
    idle(1);
    // R11 reset state
    check("R11 req", wdt_rst_req, 0);
    bus_addr = 0; #1 check("R11 ctl", bus_rdata, 0);

    // table walk
    for (int s = 0; s < NV; s++) begin
      wr(VEC[s][9], VEC[s][8:1]);
      check(tag_of(s), wdt_rst_req, VEC[s][0]);
      if (VEC[s][0]) begin
        idle(1);
        check("R10 width", wdt_rst_req, 0);
      end
    end

    // R2 readback
    wr(0, 8'hFF);
    bus_addr = 0; #1 check("R2 ctl", bus_rdata, 8'h0F);
    bus_addr = 1; #1 check("R2 svc", bus_rdata, 8'h00);
    bus_addr = 0;
    wr(0, 8'h00);

    // R7 rate 1 timeout and R10 periodic restart
    wr(0, 8'h01);
    wait_pulse(40, k);  check("R7 rate1", k, P1);
    idle(1);            check("R10 width", wdt_rst_req, 0);
    wait_pulse(40, k);  check("R10 next", k, P1 - 1);

    // R4 service extends
    wr(0, 8'h00); wr(0, 8'h01);
    idle(5); wr(1, 8'h55); idle(2); wr(1, 8'hAA);
    wait_pulse(40, k);  check("R4 restart", k, P1);

    // R7 rate 2
    wr(0, 8'h00); wr(0, 8'h02);
    wait_pulse(100, k); check("R7 rate2", k, P2);

    // R9 change restarts, same value does not
    wr(0, 8'h00); wr(0, 8'h01);
    idle(9); wr(0, 8'h02);
    wait_pulse(100, k); check("R9 change", k, P2);
    wr(0, 8'h00); wr(0, 8'h01);
    idle(8); wr(0, 8'h01);
    wait_pulse(40, k);  check("R9 same", k, P1 - 9);

    // R8 window mode
    wr(0, 8'h00); wr(0, 8'h09);
    idle(4); wr(1, 8'h55);
    check("R8 early", wdt_rst_req, 1);
    idle(OPEN1 - 1); wr(1, 8'h55);   // edge OPEN1 after restart: still closed
    check("R8 edge closed", wdt_rst_req, 1);
    idle(OPEN1); wr(1, 8'h55);       // edge OPEN1+1: open
    check("R8 open 55", wdt_rst_req, 0);
    wr(1, 8'hAA);
    check("R8 open AA", wdt_rst_req, 0);
    wait_pulse(40, k);  check("R8 restart", k, P1);

    // R1 no timeout when off
    wr(0, 8'h00);
    wait_pulse(100, k); check("R1 off", k, -1);

    finished = 1;
    summary();
  end
endmodule